// File: doc/BRIEF.md
# Multi-Port Cell Bus Receive Slave (PHY Side)

This block is the physical-layer end of a byte-wide cell bus that is shared by several ports. The master on the ATM layer supplies the byte clock, a port address and an active-low enable. The block compares the address with the port address it has been configured with. In the cycle after its own address is polled, it drives a cell-available flag. When the master lowers enable after polling this port, the block becomes the selected port. It then pulls 53-byte cells from an internal cell buffer and presents them on the data bus, with a start-of-cell marker on the first byte.

The block drives no bus pins directly. Each bus output comes with an output-enable, and the pad ring turns these into tri-state drivers. An enable is raised only for the cycle and the port that own the bus. A global force-float control drops every enable at once, so a port with a wrong address setting cannot fight another port on the bus.

On the buffer side the stream is valid/ready. The block raises `cb_ready` when it wants a byte. A byte moves on a cycle where `cb_valid` and `cb_ready` are both high. If `cb_valid` is low, the transfer waits and the byte position is kept. While `cb_valid` is high and `cb_ready` is low, the buffer must hold `cb_data` stable. `cb_cell_ready` tells the block that a whole cell is stored and can be sent.

Top module: `cellbus_rx_phy`

## Requirements
- R1: `rx_clav_oe` is high in the cycle after a clock edge that sampled `rx_addr` equal to `cfg_port_addr`. It is low in every other cycle.
- R2: `rx_clav` is registered. It is 1 when `cb_cell_ready` was high, or when a cell was part-way through transfer, at the previous edge. Otherwise it is 0. It therefore stays 1 for the whole cell.
- R3: Address 31 (all ones) is a null address. It never produces a match, even when `cfg_port_addr` is 31.
- R4: The port is selected on an edge where `rx_enb_n` is sampled low, `rx_enb_n` was high at the previous edge, and the address at that previous edge matched. An enable fall whose preceding address did not match deselects the port.
- R5: While the port is selected, `rx_enb_n` is low and a cell is pending, `cb_ready` is high. Each accepted byte appears on `rx_data` in the next cycle, with `rx_data_oe` high for that one cycle.
- R6: `rx_soc` is 1 only with byte 0 of a cell. `rx_soc_oe` follows `rx_data_oe`.
- R7: While `rx_enb_n` is high, no byte moves. When the port is selected again, the transfer resumes at the same byte.
- R8: After byte 52 (the 53rd byte) is accepted, the port is deselected and the byte position returns to 0. Further low enable moves no byte until a new selection.
- R9: `cfg_hiz_all` high forces `rx_data_oe`, `rx_soc_oe` and `rx_clav_oe` low in the same cycle, and blocks any byte transfer.
- R10: With `cb_valid` low, no byte moves and the byte position is kept.
- R11: After reset, all output-enables and `cb_ready` are low, and the port is unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock from the master |
| rst_n | input | 1 | Active-low reset |
| cfg_port_addr | input | 5 | Configured port address |
| cfg_hiz_all | input | 1 | Force every bus output-enable low |
| rx_addr | input | 5 | Poll / select address from the master |
| rx_enb_n | input | 1 | Active-low transfer enable |
| cb_cell_ready | input | 1 | A full cell is held in the buffer |
| cb_valid | input | 1 | Buffer byte valid |
| cb_ready | output | 1 | Block takes the buffer byte this cycle |
| cb_data | input | 8 | Buffer byte |
| rx_data | output | 8 | Cell byte to the bus |
| rx_data_oe | output | 1 | Drive enable for rx_data |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_soc_oe | output | 1 | Drive enable for rx_soc |
| rx_clav | output | 1 | Cell-available flag |
| rx_clav_oe | output | 1 | Drive enable for rx_clav |

## Verification
Every bus result comes one edge after the stimulus that caused it:
- `rx_clav_oe` and `rx_clav` follow the address and the pending-cell state at the previous edge.
- Data, start-of-cell and data-enable follow the byte accepted at the previous edge.

The force-float control and `cb_ready` are combinational and take effect in the same cycle. The bench drives inputs on the falling clock edge. It compares every output on the next falling edge, so each registered result is read exactly one rising edge after its stimulus. The bench's buffer model numbers the bytes it hands out, so each expected data value is that count.

// File: rtl/rxphy_pkg.sv
package rxphy_pkg;

  typedef enum logic {
    SEL_NONE = 1'b0,
    SEL_OWN  = 1'b1
  } sel_state_e;

  function automatic logic addr_is_null(input logic [7:0] addr, input int unsigned width);
    logic [7:0] ones;
    ones = 8'((1 << width) - 1);
    return (addr & ones) == ones;
  endfunction

endpackage

// File: rtl/rxphy_poll.sv
module rxphy_poll #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] cfg_port_addr,
  input  logic              cell_pending,
  output logic              hit_q,
  output logic              clav_q
);
  import rxphy_pkg::*;

  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};

  logic hit;

  always_comb begin
    hit = (rx_addr == cfg_port_addr) && (rx_addr != NULL_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      clav_q <= 1'b0;
    end else begin
      hit_q  <= hit;
      clav_q <= cell_pending;
    end
  end

  AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_addr == NULL_ADDR) |=> !hit_q); // R3

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_addr != cfg_port_addr) |=> !hit_q); // R1

endmodule

// File: rtl/rxphy_seq.sv
module rxphy_seq #(
  parameter int unsigned CELL_LEN = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_enb_n,
  input  logic hit_q,
  input  logic hiz,
  input  logic cb_cell_ready,
  input  logic cb_valid,
  output logic cb_ready,
  output logic pop,
  output logic first_byte,
  output logic cell_pending
);
  import rxphy_pkg::*;

  localparam int unsigned IDX_W = $clog2(CELL_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

  sel_state_e       sel_q;
  logic [IDX_W-1:0] byte_idx;
  logic             enb_q;
  logic             enb_fall;
  logic             sel_now;
  logic             last_byte;

  always_comb begin
    enb_fall     = enb_q && !rx_enb_n;
    sel_now      = enb_fall ? hit_q : (sel_q == SEL_OWN);
    cell_pending = (byte_idx != '0) || cb_cell_ready;
    cb_ready     = sel_now && !rx_enb_n && !hiz && cell_pending;
    pop          = cb_ready && cb_valid;
    last_byte    = (byte_idx == LAST_IDX);
    first_byte   = (byte_idx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_q    <= 1'b1;
      sel_q    <= SEL_NONE;
      byte_idx <= '0;
    end else begin
      enb_q <= rx_enb_n;
      if (pop && last_byte) begin
        sel_q    <= SEL_NONE;
        byte_idx <= '0;
      end else begin
        sel_q <= sel_now ? SEL_OWN : SEL_NONE;
        if (pop) begin
          byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx <= LAST_IDX); // R8

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enb_n |=> $stable(byte_idx)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cb_valid |=> $stable(byte_idx)); // R10

  AST_CELL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && last_byte) |=> (sel_q == SEL_NONE) && (byte_idx == '0)); // R8

  AST_HIZ_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |-> !cb_ready); // R9

endmodule

// File: rtl/rxphy_drive.sv
module rxphy_drive #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              first_byte,
  input  logic [DATA_W-1:0] cb_data,
  input  logic              hiz,
  input  logic              hit_q,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_data_oe,
  output logic              rx_soc,
  output logic              rx_soc_oe,
  output logic              rx_clav_oe
);
  logic [DATA_W-1:0] data_q;
  logic              soc_q;
  logic              doe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      soc_q  <= 1'b0;
      doe_q  <= 1'b0;
    end else begin
      doe_q <= pop;
      soc_q <= pop && first_byte;
      if (pop) begin
        data_q <= cb_data;
      end
    end
  end

  always_comb begin
    rx_data    = data_q;
    rx_soc     = soc_q;
    rx_data_oe = doe_q && !hiz;
    rx_soc_oe  = doe_q && !hiz;
    rx_clav_oe = hit_q && !hiz;
  end

  AST_SOC_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    soc_q |-> doe_q); // R6

  AST_ONE_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> !doe_q); // R5

endmodule

// File: rtl/cellbus_rx_phy.sv
module cellbus_rx_phy #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CELL_LEN = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_port_addr,
  input  logic              cfg_hiz_all,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              rx_enb_n,
  input  logic              cb_cell_ready,
  input  logic              cb_valid,
  output logic              cb_ready,
  input  logic [DATA_W-1:0] cb_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_data_oe,
  output logic              rx_soc,
  output logic              rx_soc_oe,
  output logic              rx_clav,
  output logic              rx_clav_oe
);
  logic hit_q;
  logic clav_q;
  logic pop;
  logic first_byte;
  logic cell_pending;

  rxphy_poll #(.ADDR_W(ADDR_W)) u_poll (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_addr       (rx_addr),
    .cfg_port_addr (cfg_port_addr),
    .cell_pending  (cell_pending),
    .hit_q         (hit_q),
    .clav_q        (clav_q)
  );

  rxphy_seq #(.CELL_LEN(CELL_LEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enb_n      (rx_enb_n),
    .hit_q         (hit_q),
    .hiz           (cfg_hiz_all),
    .cb_cell_ready (cb_cell_ready),
    .cb_valid      (cb_valid),
    .cb_ready      (cb_ready),
    .pop           (pop),
    .first_byte    (first_byte),
    .cell_pending  (cell_pending)
  );

  rxphy_drive #(.DATA_W(DATA_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop        (pop),
    .first_byte (first_byte),
    .cb_data    (cb_data),
    .hiz        (cfg_hiz_all),
    .hit_q      (hit_q),
    .rx_data    (rx_data),
    .rx_data_oe (rx_data_oe),
    .rx_soc     (rx_soc),
    .rx_soc_oe  (rx_soc_oe),
    .rx_clav_oe (rx_clav_oe)
  );

  assign rx_clav = clav_q;

  AST_FLOAT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hiz_all |-> !(rx_data_oe || rx_soc_oe || rx_clav_oe)); // R9

  AST_SOC_ENABLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soc_oe == rx_data_oe); // R6

endmodule

// File: tb/cellbus_rx_phy_test.sv
module cellbus_rx_phy_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_port_addr = 5'd5;
  logic       cfg_hiz_all = 1'b0;
  logic [4:0] rx_addr = 5'd0;
  logic       rx_enb_n = 1'b1;
  logic       cb_cell_ready = 1'b0;
  logic       cb_valid = 1'b1;
  logic       cb_ready;
  logic [7:0] cb_data;
  logic [7:0] rx_data;
  logic       rx_data_oe, rx_soc, rx_soc_oe, rx_clav, rx_clav_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] pop_cnt;

  always #2 clk = ~clk;

  cellbus_rx_phy uut (
    .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr), .cfg_hiz_all(cfg_hiz_all),
    .rx_addr(rx_addr), .rx_enb_n(rx_enb_n), .cb_cell_ready(cb_cell_ready),
    .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_data(cb_data),
    .rx_data(rx_data), .rx_data_oe(rx_data_oe), .rx_soc(rx_soc), .rx_soc_oe(rx_soc_oe),
    .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
  );

  // Buffer model: hands out an incrementing byte count.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_cnt <= '0;
    else if (cb_ready && cb_valid) pop_cnt <= pop_cnt + 1'b1;
  end
  assign cb_data = pop_cnt[7:0];

  typedef struct packed {
    logic [4:0] addr;
    logic       enb_n;
    logic       hiz;
    logic       e_coe;
    logic       e_clav;
    logic       e_doe;
    logic       e_soc;
    logic [7:0] e_data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0}, // R1 own poll
    '{5'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0}, // R1 foreign poll
    '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0}, // R2 cell ready
    '{5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0}, // R4 select, R6 soc
    '{5'd31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1}, // R5 next byte
    '{5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1}, // R7 pause
    '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1}, // R2 mid cell
    '{5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2}, // R7 resume
    '{5'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2}, // R4 other poll
    '{5'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2}, // R4 deselect
    '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2}, // R1 repoll
    '{5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3}, // R4 reselect
    '{5'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3}, // R9 float
    '{5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd4}  // R9 release
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [4:0] a, input logic en, input logic hz);
    rx_addr = a;
    rx_enb_n = en;
    cfg_hiz_all = hz;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cb_cell_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 data_oe", {7'd0, rx_data_oe}, 8'd0);
    chk("R11 clav_oe", {7'd0, rx_clav_oe}, 8'd0);
    chk("R11 cb_ready", {7'd0, cb_ready}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].addr, VECS[i].enb_n, VECS[i].hiz);
      chk("R1/R9 clav_oe", {7'd0, rx_clav_oe}, {7'd0, VECS[i].e_coe});
      if (VECS[i].e_coe) chk("R2 clav", {7'd0, rx_clav}, {7'd0, VECS[i].e_clav});
      chk("R5/R9 data_oe", {7'd0, rx_data_oe}, {7'd0, VECS[i].e_doe});
      if (VECS[i].e_doe) begin
        chk("R5 data", rx_data, VECS[i].e_data);
        chk("R6 soc", {7'd0, rx_soc}, {7'd0, VECS[i].e_soc});
        chk("R6 soc_oe", {7'd0, rx_soc_oe}, 8'd1);
      end
    end

    // R8 finish the cell: bytes 5..52
    for (int k = 5; k < 53; k++) begin
      step(5'd5, 1'b0, 1'b0);
      chk("R5 body data_oe", {7'd0, rx_data_oe}, 8'd1);
      chk("R5 body data", rx_data, 8'(k));
      chk("R6 body soc", {7'd0, rx_soc}, 8'd0);
    end
    cb_cell_ready = 1'b0;
    step(5'd5, 1'b0, 1'b0);
    chk("R8 deselect after byte 52", {7'd0, rx_data_oe}, 8'd0);
    chk("R8 pop count", pop_cnt[7:0], 8'd53);
    step(5'd5, 1'b1, 1'b0);
    chk("R2 clav_oe", {7'd0, rx_clav_oe}, 8'd1);
    chk("R2 no cell clav", {7'd0, rx_clav}, 8'd0);
    step(5'd5, 1'b0, 1'b0);
    chk("R5 no cell no byte", {7'd0, rx_data_oe}, 8'd0);
    chk("R5 no cell cb_ready", {7'd0, cb_ready}, 8'd0);

    // R10 back-pressure with a new cell
    cb_cell_ready = 1'b1;
    step(5'd5, 1'b1, 1'b0);
    cb_valid = 1'b0;
    step(5'd5, 1'b0, 1'b0);
    chk("R10 stall data_oe", {7'd0, rx_data_oe}, 8'd0);
    chk("R10 stall cb_ready", {7'd0, cb_ready}, 8'd1);
    cb_valid = 1'b1;
    step(5'd5, 1'b0, 1'b0);
    chk("R10 resume data_oe", {7'd0, rx_data_oe}, 8'd1);
    chk("R10 resume data", rx_data, 8'd53);
    chk("R10 resume soc", {7'd0, rx_soc}, 8'd1);

    // R3 null address configured
    step(5'd5, 1'b1, 1'b0);
    cfg_port_addr = 5'd31;
    step(5'd31, 1'b1, 1'b0);
    chk("R3 null poll", {7'd0, rx_clav_oe}, 8'd0);
    step(5'd31, 1'b0, 1'b0);
    chk("R3 null select", {7'd0, rx_data_oe}, 8'd0);
    cfg_port_addr = 5'd5;

    // R9 float applies in the same cycle
    step(5'd5, 1'b1, 1'b0);
    cfg_hiz_all = 1'b1;
    #0.5;
    chk("R9 immediate clav_oe", {7'd0, rx_clav_oe}, 8'd0);
    cfg_hiz_all = 1'b0;
    #0.5;
    chk("R9 released clav_oe", {7'd0, rx_clav_oe}, 8'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule